// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus (clock and open-drain data). Through it a host controller reads and writes a small bank of byte-wide configuration registers, for example one enable bit per clock output. The register contents also appear all the time on a parallel output bus, so neighbouring logic can use them directly. Both bus lines are sampled by a fast system clock through synchronizers. The slave pulls the data line low only through an output-enable pin.

Every transaction opens with the device address byte and then a command byte. When the top bit of the command is set, the low seven bits give the offset of one register, which is then written or read. When the top bit is clear, a block transfer starts at register zero. A block write sends a byte-count byte before the data. A block read returns the register count first and then the registers in ascending order. To read, the host sends a repeated start after the command and then the read address. The host may stop a block transfer after any whole byte.

Top module: `cfg_twowire_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (7-bit address 0x69, write) and 0xD3 (read), the command byte and every written byte. It does this by asserting `sda_oe_o` through the ninth clock of the byte.
- R2: After any other address byte, the slave never asserts `sda_oe_o` until the next start or stop, and no register changes.
- R3: A command byte with bit 7 = 1 followed by one data byte writes that byte to the register at offset bits 6:0. The new value is visible on `regs_o` (register i at bits 8i+7:8i) before the acknowledge clock ends.
- R4: After an indexed command (bit 7 = 1), a repeated start and the read address, the slave returns the register at that offset, most significant bit first. While SCL is high it holds SDA steady.
- R5: A command byte of 0x00 starts a block write. The next byte is a count and is ignored. The data bytes after it go to registers 0, 1, 2 and so on, in that order.
- R6: When a block write is ended by a stop after any whole data byte, every completed byte takes effect and the higher registers keep their values.
- R7: After a 0x00 command, a repeated start and the read address, the slave returns the count byte (equal to the number of registers), then registers 0, 1, 2 and so on. After the host's not-acknowledge it releases SDA.
- R8: An access to an offset at or beyond the register count is acknowledged. A write there changes nothing, and a read there returns 0x00.
- R9: Reset loads every register with its default value (parameter `RST_VAL`) and releases SDA.
- R10: A stop condition returns the slave to idle from any state. A byte cut short by a stop is not written, and the next transaction works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | When high, the data line is pulled low |
| regs_o | output | NREG*8 | Register bank contents, register i at bits 8i+7:8i |

## Verification
The assertions assume that the host changes SDA only while SCL is low, except when it makes start and stop conditions. They also assume that each bus level is held for more system clocks than the synchronizer delay, so a rising or falling SCL edge and the SDA value around it are seen in a consistent order. The bench master holds every bus phase for ten system clocks and changes SDA only at the middle of the low phase of SCL. The acknowledge and read-data phases come from the slave; the bench master leaves SDA released during them.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RX_END, S_ACK, S_TX, S_TACK, S_TNEXT, S_WAIT
  } tws_state_t;

  typedef enum logic [1:0] {
    K_ADDR, K_CMD, K_WCNT, K_WDATA
  } tws_kind_t;
endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[LAST-1:0], scl_i};
      sda_p <= {sda_p[LAST-1:0], sda_i};
    end
  end

  assign scl_lvl  = scl_p[LAST-1];
  assign sda_lvl  = sda_p[LAST-1];
  assign scl_rise = scl_p[LAST-1] & ~scl_p[LAST];
  assign scl_fall = ~scl_p[LAST-1] & scl_p[LAST];
  // data edges while the clock stays high mark start / stop
  assign start_o  = scl_p[LAST-1] & scl_p[LAST] & sda_p[LAST] & ~sda_p[LAST-1];
  assign stop_o   = scl_p[LAST-1] & scl_p[LAST] & ~sda_p[LAST] & sda_p[LAST-1];
endmodule

// File: rtl/tws_reg_bank.sv
module tws_reg_bank #(
  parameter int               NREG    = 8,
  parameter int               AW      = 7,
  parameter logic [NREG*8-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_flat
);
  logic [7:0] mem [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        mem[gi] <= RST_VAL[gi*8 +: 8];
      else if (wr_en && wr_addr == AW'(gi))
        mem[gi] <= wr_data;
    end
    assign regs_flat[gi*8 +: 8] = mem[gi];
  end

  // unmatched offsets fall through to zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == AW'(i)) rd_data = mem[i];
  end

  AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) >= NREG) |=> $stable(regs_flat)) else $error("write beyond bank changed a register"); // R8
  AST_RESET_LOADS_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> regs_flat == RST_VAL) else $error("bank not at defaults after reset"); // R9
endmodule

// File: rtl/tws_proto_fsm.sv
module tws_proto_fsm
  import tws_pkg::*;
#(
  parameter int         NREG     = 8,
  parameter int         AW       = 7,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);
  localparam logic [7:0] CNT_BYTE = 8'(NREG);

  tws_state_t    state;
  tws_kind_t     kind;
  logic [2:0]    cnt;
  logic [7:0]    rx_sh, tx_sh;
  logic [AW-1:0] ptr;
  logic          blk_mode, send_cnt, go_tx;
  logic [7:0]    rx_byte, next_tx;

  assign rx_byte = {rx_sh[6:0], sda_lvl};
  assign next_tx = send_cnt ? CNT_BYTE : rd_data;
  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      kind     <= K_ADDR;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      ptr      <= '0;
      blk_mode <= 1'b0;
      send_cnt <= 1'b0;
      go_tx    <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_i) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_i) begin
        state  <= S_RX;
        kind   <= K_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_RX: if (scl_rise) begin
            rx_sh <= rx_byte;
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              state <= S_RX_END;
              go_tx <= 1'b0;
              case (kind)
                K_ADDR: begin
                  if (rx_byte[7:1] != DEV_ADDR) begin
                    state <= S_WAIT;
                  end else if (rx_byte[0]) begin
                    go_tx    <= 1'b1;
                    send_cnt <= blk_mode;
                  end else begin
                    kind <= K_CMD;
                  end
                end
                K_CMD: begin
                  blk_mode <= ~rx_byte[7];
                  ptr      <= rx_byte[7] ? rx_byte[AW-1:0] : '0;
                  kind     <= rx_byte[7] ? K_WDATA : K_WCNT;
                end
                K_WCNT: kind <= K_WDATA;
                K_WDATA: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= rx_byte;
                  ptr     <= ptr + 1'b1;
                end
                default: ;
              endcase
            end
          end
          S_RX_END: if (scl_fall) begin
            state  <= S_ACK;
            sda_oe <= 1'b1;
          end
          S_ACK: if (scl_fall) begin
            cnt <= '0;
            if (go_tx) begin
              state  <= S_TX;
              tx_sh  <= next_tx;
              sda_oe <= ~next_tx[7];
              if (send_cnt) send_cnt <= 1'b0;
              else          ptr      <= ptr + 1'b1;
            end else begin
              state  <= S_RX;
              sda_oe <= 1'b0;
            end
          end
          S_TX: if (scl_fall) begin
            if (cnt == 3'd7) begin
              state  <= S_TACK;
              sda_oe <= 1'b0;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
              cnt    <= cnt + 3'd1;
            end
          end
          S_TACK: if (scl_rise) state <= sda_lvl ? S_WAIT : S_TNEXT;
          S_TNEXT: if (scl_fall) begin
            state  <= S_TX;
            cnt    <= '0;
            tx_sh  <= next_tx;
            sda_oe <= ~next_tx[7];
            if (send_cnt) send_cnt <= 1'b0;
            else          ptr      <= ptr + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_ACK_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    state == S_ACK |-> sda_oe) else $error("acknowledge slot not driven"); // R1
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    state == S_WAIT |-> !sda_oe) else $error("data driven while ignoring bus"); // R2
  AST_TX_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == S_TX && scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe)) else $error("read data moved while clock high"); // R4
  AST_WRITE_ONLY_DATA: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(kind) == K_WDATA) else $error("write from non-data byte"); // R5
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> state == S_IDLE) else $error("stop did not reach idle"); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    state == S_IDLE |-> !sda_oe) else $error("data driven in idle"); // R10
endmodule

// File: rtl/cfg_twowire_slave.sv
module cfg_twowire_slave #(
  parameter int                NREG        = 8,
  parameter logic [6:0]        DEV_ADDR    = 7'h69,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NREG*8-1:0] RST_VAL     = 64'h8877_6655_4433_2211
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o
);
  localparam int AW = 7;

  logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_c, stop_c;
  logic [7:0]    rd_data, wr_data;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          wr_en;

  tws_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_o(start_c), .stop_o(stop_c)
  );

  tws_proto_fsm #(.NREG(NREG), .AW(AW), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_i(start_c),
    .stop_i(stop_c), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe_o)
  );

  tws_reg_bank #(.NREG(NREG), .AW(AW), .RST_VAL(RST_VAL)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .regs_flat(regs_o)
  );
endmodule

// File: tb/cfg_twowire_slave_test.sv
`timescale 1ns/1ps
module cfg_twowire_slave_test;
  localparam int NREG = 8;
  localparam int Q = 10;
  localparam logic [NREG*8-1:0] DEFS = 64'h8877_6655_4433_2211;
  // {offset, value} for indexed write then indexed read-back
  localparam logic [15:0] VEC [6] = '{16'h003C, 16'h05A7, 16'h07FE,
                                      16'h0955, 16'h7F12, 16'h0200};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  logic sda_line;
  int n_chk = 0, n_fail = 0, oe_cnt = 0;
  logic [7:0] mdl [NREG];

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  cfg_twowire_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  always @(posedge clk) if (sda_oe) oe_cnt <= oe_cnt + 1;

  function automatic logic [NREG*8-1:0] packm();
    logic [NREG*8-1:0] r;
    for (int i = 0; i < NREG; i++) r[i*8 +: 8] = mdl[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask
  task automatic t_start; sda_m = 1; wq; scl_m = 1; wq; sda_m = 0; wq; scl_m = 0; wq; endtask
  task automatic t_stop; sda_m = 0; wq; scl_m = 1; wq; sda_m = 1; wq; endtask
  task automatic bit_out(input logic b); sda_m = b; wq; scl_m = 1; wq; wq; scl_m = 0; wq; endtask
  task automatic bit_in(output logic b); sda_m = 1; wq; scl_m = 1; wq; b = sda_line; wq; scl_m = 0; wq; endtask

  task automatic send_byte(input logic [7:0] d, inout int acks);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    if (!b) acks++;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(~ack);
  endtask

  task automatic byte_wr(input logic [7:0] off, input logic [7:0] val, output int acks);
    acks = 0;
    t_start; send_byte(8'hD2, acks); send_byte({1'b1, off[6:0]}, acks);
    send_byte(val, acks); t_stop;
  endtask

  task automatic byte_rd(input logic [7:0] off, output logic [7:0] val);
    int acks = 0;
    t_start; send_byte(8'hD2, acks); send_byte({1'b1, off[6:0]}, acks);
    t_start; send_byte(8'hD3, acks); recv_byte(val, 1'b0); t_stop;
  endtask

  initial begin
    int acks, oe0;
    logic [7:0] v;
    for (int i = 0; i < NREG; i++) mdl[i] = DEFS[i*8 +: 8];
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset regs", 64'(regs), 64'(DEFS));
    chk("R9 reset sda", 64'(sda_oe), 64'd0);

    // vector table: indexed write, bank view, indexed read-back
    foreach (VEC[k]) begin
      logic [7:0] off = VEC[k][15:8];
      logic [7:0] val = VEC[k][7:0];
      logic [7:0] expv;
      byte_wr(off, val, acks);
      chk("R1 acks addr/cmd/data", 64'(acks), 64'd3);
      if (off < NREG) mdl[off] = val;
      expv = (off < NREG) ? val : 8'h00;
      chk(off < NREG ? "R3 indexed write" : "R8 write beyond bank", 64'(regs), 64'(packm()));
      byte_rd(off, v);
      chk(off < NREG ? "R4 indexed read" : "R8 read beyond bank", 64'(v), 64'(expv));
    end

    // R2: foreign address, no drive, nothing changes
    oe0 = oe_cnt; acks = 0;
    t_start; send_byte(8'hA4, acks); send_byte(8'h81, acks); send_byte(8'h99, acks); t_stop;
    t_start; send_byte(8'hD0, acks); send_byte(8'h80, acks); t_stop;
    chk("R2 no ack", 64'(acks), 64'd0);
    chk("R2 sda never driven", 64'(oe_cnt - oe0), 64'd0);
    chk("R2 regs unchanged", 64'(regs), 64'(packm()));

    // R5: full block write
    acks = 0;
    t_start; send_byte(8'hD2, acks); send_byte(8'h00, acks); send_byte(8'h08, acks);
    for (int i = 0; i < NREG; i++) begin send_byte(8'hB0 + 8'(i), acks); mdl[i] = 8'hB0 + 8'(i); end
    t_stop;
    chk("R5 block write acks", 64'(acks), 64'(NREG + 3));
    chk("R5 block write order", 64'(regs), 64'(packm()));

    // R6: block write cut short after three data bytes
    acks = 0;
    t_start; send_byte(8'hD2, acks); send_byte(8'h00, acks); send_byte(8'h08, acks);
    for (int i = 0; i < 3; i++) begin send_byte(8'hC0 + 8'(i), acks); mdl[i] = 8'hC0 + 8'(i); end
    t_stop;
    chk("R6 partial block write", 64'(regs), 64'(packm()));

    // R7 / R8: block read past the end
    acks = 0;
    t_start; send_byte(8'hD2, acks); send_byte(8'h00, acks);
    t_start; send_byte(8'hD3, acks);
    recv_byte(v, 1'b1);
    chk("R7 count byte", 64'(v), 64'(NREG));
    for (int i = 0; i < NREG + 2; i++) begin
      recv_byte(v, i != NREG + 1);
      if (i < NREG) chk("R7 block read data", 64'(v), 64'(mdl[i]));
      else          chk("R8 block read beyond", 64'(v), 64'd0);
    end
    chk("R7 released after nack", 64'(sda_oe), 64'd0);
    t_stop;

    // R10: stop in the middle of a data byte
    acks = 0;
    t_start; send_byte(8'hD2, acks); send_byte(8'h83, acks);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    t_stop;
    chk("R10 cut byte not written", 64'(regs), 64'(packm()));
    chk("R10 idle after stop", 64'(sda_oe), 64'd0);
    byte_wr(8'h03, 8'h6C, acks);
    mdl[3] = 8'h6C;
    chk("R10 next transaction acks", 64'(acks), 64'd3);
    chk("R10 next transaction write", 64'(regs), 64'(packm()));

    // R9: reset in mid transaction
    acks = 0;
    t_start; send_byte(8'hD2, acks); send_byte(8'h81, acks);
    @(negedge clk); rst = 1; repeat (3) @(negedge clk); rst = 0;
    @(negedge clk);
    for (int i = 0; i < NREG; i++) mdl[i] = DEFS[i*8 +: 8];
    chk("R9 mid reset regs", 64'(regs), 64'(DEFS));
    chk("R9 mid reset sda", 64'(sda_oe), 64'd0);
    t_stop;
    byte_rd(8'h06, v);
    chk("R9 default read after reset", 64'(v), 64'(DEFS[6*8 +: 8]));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule